// File: doc/BRIEF.md
# AES coprocessor register access controller

This block is the byte-wide register front end and sequencer placed in front of a 128-bit block cipher engine. A memory-style access port delivers a byte address, write data, read and write strobes and a marker for the last byte of a burst. The block decodes a small window holding a status byte, a control byte, a mirror of the control byte and a sixteen-byte window. Depending on the selected mode, that window reaches either the cipher key or the 128-bit data block.

Writing the control byte, or its mirror, with the request bit set launches an operation. A host can therefore stream sixteen data bytes and end the same burst with a mirror write that starts processing. The block then sends a one-cycle launch pulse to the engine and holds the done flag low for a fixed number of clock cycles. That count stands for 24 µs at the configured clock rate. When the count runs out, the block copies the engine result into the data block and raises done. The block raises an error flag in two cases: when the control byte is touched while the engine is working, and when a readout burst after completion collects only part of the result. A sleep input clears every register synchronously.

Top module: `aes_ctl_regs`

## Requirements
- R1: After reset, the status byte (0x82) and the control byte (0x83) both read 0x00, and the engine launch output is low.
- R2: Address 0x82 reads as {error, 6'b0, done}, with error in bit 7 and done in bit 0. Writes to 0x82 change nothing.
- R3: Address 0x83 stores mode in bits 6:4 and direction in bit 3 (1 = decrypt). Bit 7 (request) and bits 2:0 always read 0.
- R4: Address 0x94 reads the same value as 0x83. Writing 0x94 updates mode and direction exactly as a write to 0x83 does.
- R5: Byte i of the window, at address 0x84+i, maps to bits 8i+7:8i. It reaches the key when mode is 1 and the data block for any other mode.
- R6: A write to 0x83 or 0x94 with bit 7 set while idle starts an operation. That start clears done and error, and in the next cycle the launch output is high for exactly one cycle. During that cycle the launch output carries the key, data block, mode and direction.
- R7: Done stays 0 for PROC_CYC clock cycles after the start write. It then becomes 1, and in the same cycle the data block takes the engine result.
- R8: Any read or write of 0x83 or 0x94 while an operation runs sets error. Such a write does not change the control byte.
- R9: When done is 1 and mode is not 1, a burst that ends after reading at least one but fewer than all 16 distinct window bytes sets error.
- R10: Reading all 16 window bytes within one burst after completion leaves error at 0.
- R11: Addresses 0x80, 0x81 and 0x95 to 0xFF read 0x00, and writes to them change no register.
- R12: While the sleep input is high at a clock edge, all registers return to their reset values, and a running operation is abandoned without ever raising done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | Synchronous clear of all registers |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe, one byte per cycle |
| bus_burst_end | input | 1 | Marks the last byte of a burst |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| eng_go | output | 1 | One-cycle engine launch pulse |
| eng_key | output | 128 | Key presented to the engine |
| eng_blk | output | 128 | Data block presented to the engine |
| eng_mode | output | 3 | Mode presented to the engine |
| eng_decrypt | output | 1 | Direction presented to the engine |
| eng_result | input | 128 | Engine result, sampled when the latency expires |

## Verification
The hardest state to reach from the ports is a readout error that sits right next to a control-while-busy error without the two being confused. The stimulus first triggers the busy-control error during one operation. It then starts a new operation through the mirror address, confirms that the start cleared the flag, waits out the full latency, and ends a five-byte read burst so that only the partial-readout path can set the flag again. The bench chains results from one operation into the next by its own model of the engine stub. Those chained results confirm the expiry latch, and a separate sleep pulse in mid-operation confirms that done never appears afterwards.

// File: rtl/aes_ctl_pkg.sv
package aes_ctl_pkg;

  localparam int BLK_BYTES = 16;
  localparam int BLK_W     = BLK_BYTES * 8;
  localparam int IDX_W     = $clog2(BLK_BYTES);
  localparam int MODE_W    = 3;

  localparam logic [7:0] ADR_STAT = 8'h82;
  localparam logic [7:0] ADR_CTRL = 8'h83;
  localparam logic [7:0] ADR_WIN0 = 8'h84;
  localparam logic [7:0] ADR_MIRR = 8'h94;

  localparam logic [MODE_W-1:0] MODE_KEYWIN = 3'd1;

  // bit positions inside the control byte
  localparam int CB_REQ  = 7;
  localparam int CB_DIR  = 3;
  localparam int CB_MODE = 4;

  function automatic logic [7:0] pack_status(input logic err, input logic done);
    return {err, 6'b000000, done};
  endfunction

  function automatic logic [7:0] pack_ctrl(input logic [MODE_W-1:0] mode, input logic dir);
    return {1'b0, mode, dir, 3'b000};
  endfunction

  function automatic logic [7:0] blk_byte(input logic [BLK_W-1:0] v, input logic [IDX_W-1:0] i);
    return v[i*8 +: 8];
  endfunction

  function automatic logic [BLK_W-1:0] blk_put(input logic [BLK_W-1:0] v,
                                               input logic [IDX_W-1:0] i,
                                               input logic [7:0] b);
    logic [BLK_W-1:0] r;
    r = v;
    r[i*8 +: 8] = b;
    return r;
  endfunction

endpackage

// File: rtl/aes_ctl_decode.sv
module aes_ctl_decode
  import aes_ctl_pkg::*;
(
  input  logic [7:0]       addr,
  output logic             hit_stat,
  output logic             hit_ctrl,
  output logic             hit_mirr,
  output logic             hit_win,
  output logic             hit_rsvd,
  output logic [IDX_W-1:0] win_idx
);
  localparam logic [7:0] ADR_WINL = ADR_WIN0 + 8'(BLK_BYTES - 1);

  logic [7:0] offs;

  always_comb begin
    offs     = addr - ADR_WIN0;
    hit_stat = (addr == ADR_STAT);
    hit_ctrl = (addr == ADR_CTRL);
    hit_mirr = (addr == ADR_MIRR);
    hit_win  = (addr >= ADR_WIN0) && (addr <= ADR_WINL);
    hit_rsvd = !(hit_stat || hit_ctrl || hit_mirr || hit_win);
    win_idx  = offs[IDX_W-1:0];
  end
endmodule

// File: rtl/aes_ctl_timer.sv
module aes_ctl_timer #(
  parameter int CYC = 384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start,
  output logic busy,
  output logic expire
);
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clr)            cnt_q <= '0;
    else if (start)          cnt_q <= CW'(CYC);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy   = (cnt_q != '0);
  assign expire = (cnt_q == CW'(1));
endmodule

// File: rtl/aes_ctl_rdtrack.sv
module aes_ctl_rdtrack
  import aes_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             arm,
  input  logic             rd_hit,
  input  logic [IDX_W-1:0] idx,
  input  logic             burst_end,
  output logic             partial
);
  logic [BLK_BYTES-1:0] mask_q, mask_nxt, one_hot;

  always_comb begin
    one_hot  = '0;
    one_hot[idx] = 1'b1;
    mask_nxt = mask_q;
    if (arm && rd_hit) mask_nxt = mask_q | one_hot;
    partial  = burst_end && (mask_nxt != '0) && (mask_nxt != '1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mask_q <= '0;
    else if (clr)        mask_q <= '0;
    else if (burst_end)  mask_q <= '0;
    else                 mask_q <= mask_nxt;
  end
endmodule

// File: rtl/aes_ctl_regs.sv
module aes_ctl_regs
  import aes_ctl_pkg::*;
#(
  parameter int CLK_MHZ = 16,
  parameter int PROC_US = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_i,
  input  logic [7:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic             bus_burst_end,
  output logic [7:0]       bus_rdata,
  output logic             eng_go,
  output logic [BLK_W-1:0] eng_key,
  output logic [BLK_W-1:0] eng_blk,
  output logic [2:0]       eng_mode,
  output logic             eng_decrypt,
  input  logic [BLK_W-1:0] eng_result
);
  localparam int PROC_CYC = CLK_MHZ * PROC_US;

  logic             hit_stat, hit_ctrl, hit_mirr, hit_win, hit_rsvd;
  logic [IDX_W-1:0] win_idx;

  logic [BLK_W-1:0]  key_q, blk_q;
  logic [MODE_W-1:0] mode_q;
  logic              dir_q, done_q, err_q, go_q;

  logic busy, expire_evt, start_evt, busy_hit, partial_evt;
  logic ctrl_sel, ctrl_wr, win_is_key, key_wr, blk_wr, rd_data_win;

  aes_ctl_decode u_dec (
    .addr     (bus_addr),
    .hit_stat (hit_stat),
    .hit_ctrl (hit_ctrl),
    .hit_mirr (hit_mirr),
    .hit_win  (hit_win),
    .hit_rsvd (hit_rsvd),
    .win_idx  (win_idx)
  );

  always_comb begin
    ctrl_sel    = hit_ctrl || hit_mirr;
    busy_hit    = ctrl_sel && (bus_rd || bus_wr) && busy;
    ctrl_wr     = ctrl_sel && bus_wr && !busy;
    start_evt   = ctrl_wr && bus_wdata[CB_REQ];
    win_is_key  = (mode_q == MODE_KEYWIN);
    key_wr      = bus_wr && hit_win && win_is_key;
    blk_wr      = bus_wr && hit_win && !win_is_key;
    rd_data_win = bus_rd && hit_win && !win_is_key;
  end

  aes_ctl_timer #(.CYC(PROC_CYC)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (sleep_i),
    .start  (start_evt),
    .busy   (busy),
    .expire (expire_evt)
  );

  aes_ctl_rdtrack u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (sleep_i || start_evt),
    .arm       (done_q && !busy),
    .rd_hit    (rd_data_win),
    .idx       (win_idx),
    .burst_end (bus_burst_end),
    .partial   (partial_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q  <= '0;
      blk_q  <= '0;
      mode_q <= '0;
      dir_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      go_q   <= 1'b0;
    end else if (sleep_i) begin
      key_q  <= '0;
      blk_q  <= '0;
      mode_q <= '0;
      dir_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      go_q   <= 1'b0;
    end else begin
      go_q <= start_evt;
      if (ctrl_wr) begin
        mode_q <= bus_wdata[CB_MODE +: MODE_W];
        dir_q  <= bus_wdata[CB_DIR];
      end
      if (key_wr) key_q <= blk_put(key_q, win_idx, bus_wdata);
      if (expire_evt)  blk_q <= eng_result;
      else if (blk_wr) blk_q <= blk_put(blk_q, win_idx, bus_wdata);
      if (start_evt)       done_q <= 1'b0;
      else if (expire_evt) done_q <= 1'b1;
      if (start_evt)                     err_q <= 1'b0;
      else if (busy_hit || partial_evt)  err_q <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (hit_stat)      bus_rdata = pack_status(err_q, done_q);
    else if (ctrl_sel) bus_rdata = pack_ctrl(mode_q, dir_q);
    else if (hit_win)  bus_rdata = win_is_key ? blk_byte(key_q, win_idx)
                                              : blk_byte(blk_q, win_idx);
  end

  assign eng_go      = go_q;
  assign eng_key     = key_q;
  assign eng_blk     = blk_q;
  assign eng_mode    = mode_q;
  assign eng_decrypt = dir_q;
endmodule

// File: rtl/aes_ctl_chk.sv
module aes_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_i,
  input logic       start_evt,
  input logic       expire_evt,
  input logic       busy_hit,
  input logic       partial_evt,
  input logic       busy,
  input logic       done_q,
  input logic       err_q,
  input logic       eng_go,
  input logic       hit_rsvd,
  input logic [7:0] bus_addr,
  input logic [7:0] bus_rdata
);
  a_r6_go_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt && !sleep_i |=> eng_go && !done_q && !err_q);

  a_r6_go_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    eng_go |=> !eng_go);

  a_r7_done_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt && !sleep_i |=> done_q);

  a_r7_no_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done_q);

  a_r8_busy_ctrl_err: assert property (@(posedge clk) disable iff (!rst_n)
    busy_hit && !sleep_i |=> err_q);

  a_r9_partial_err: assert property (@(posedge clk) disable iff (!rst_n)
    partial_evt && !start_evt && !sleep_i |=> err_q);

  a_r2_status_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == 8'h82 |-> bus_rdata[6:1] == 6'b0);

  a_r11_rsvd_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    hit_rsvd |-> bus_rdata == 8'h00);

  a_r12_sleep_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> !done_q && !err_q && !busy && !eng_go);
endmodule

bind aes_ctl_regs aes_ctl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sleep_i     (sleep_i),
  .start_evt   (start_evt),
  .expire_evt  (expire_evt),
  .busy_hit    (busy_hit),
  .partial_evt (partial_evt),
  .busy        (busy),
  .done_q      (done_q),
  .err_q       (err_q),
  .eng_go      (eng_go),
  .hit_rsvd    (hit_rsvd),
  .bus_addr    (bus_addr),
  .bus_rdata   (bus_rdata)
);

// File: tb/aes_ctl_regs_tb_top.sv
module aes_ctl_regs_tb_top;
  localparam int CLK_PER = 10;
  localparam int LAT     = 16 * 24;
  localparam int WDOG    = 150000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sleep_i = 1'b0;
  logic [7:0]   bus_addr = 8'h00, bus_wdata = 8'h00;
  logic         bus_wr = 1'b0, bus_rd = 1'b0, bus_burst_end = 1'b0;
  logic [7:0]   bus_rdata;
  logic         eng_go, eng_decrypt;
  logic [127:0] eng_key, eng_blk, eng_result;
  logic [2:0]   eng_mode;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  aes_ctl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_burst_end(bus_burst_end), .bus_rdata(bus_rdata),
    .eng_go(eng_go), .eng_key(eng_key), .eng_blk(eng_blk), .eng_mode(eng_mode),
    .eng_decrypt(eng_decrypt), .eng_result(eng_result)
  );

  // engine stand-in: captures its inputs at launch, answers with a simple mix
  logic [127:0] cap_key, cap_blk;
  logic         cap_dec;
  always_ff @(posedge clk) if (eng_go) begin
    cap_key <= eng_key; cap_blk <= eng_blk; cap_dec <= eng_decrypt;
  end
  assign eng_result = cap_blk ^ cap_key ^ {16{cap_dec ? 8'hA5 : 8'h3C}};

  function automatic logic [127:0] model(input logic [127:0] k, input logic [127:0] b, input logic d);
    logic [127:0] r;
    for (int i = 0; i < 16; i++) r[i*8 +: 8] = b[i*8 +: 8] ^ k[i*8 +: 8] ^ (d ? 8'hA5 : 8'h3C);
    return r;
  endfunction

  task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic be);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_burst_end = be;
    @(negedge clk);
    bus_wr = 1'b0; bus_burst_end = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic be, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1; bus_burst_end = be;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; bus_burst_end = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // write address, write data, read address, expected read value
  localparam logic [31:0] TBL [8] = '{
    32'h83_18_83_18, 32'h83_7F_83_78, 32'h94_20_83_20, 32'h83_08_94_08,
    32'h82_FF_82_00, 32'h80_55_80_00, 32'h95_AA_FF_00, 32'h83_10_83_10
  };

  initial begin
    int cyc = 0;
    while (!finished && cyc < WDOG) begin @(posedge clk); cyc++; end
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [127:0] key, blk, res, got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    peek(8'h82, v); chk("R1 status after reset", 128'(v), 128'h00);
    peek(8'h83, v); chk("R1 control after reset", 128'(v), 128'h00);
    chk("R1 launch low after reset", 128'(eng_go), 128'h0);

    // R2/R3/R4/R11 register table
    for (int i = 0; i < 8; i++) begin
      wr(TBL[i][31:24], TBL[i][23:16], 1'b0);
      rd(TBL[i][15:8], 1'b0, v);
      chk($sformatf("R2/R3/R4/R11 table entry %0d", i), 128'(v), 128'(TBL[i][7:0]));
    end
    peek(8'h82, v); chk("R11 reserved writes left status clear", 128'(v), 128'h00);

    // R5: key window in mode 1, data window otherwise
    for (int i = 0; i < 16; i++) key[i*8 +: 8] = 8'(8'h10 + i*7);
    for (int i = 0; i < 16; i++) blk[i*8 +: 8] = 8'(8'hA0 ^ i);
    for (int i = 0; i < 16; i++) wr(8'(8'h84 + i), key[i*8 +: 8], 1'b0);
    wr(8'h83, 8'h00, 1'b0);
    for (int i = 0; i < 16; i++) wr(8'(8'h84 + i), blk[i*8 +: 8], 1'b0);
    peek(8'h89, v); chk("R5 data byte 5 in mode 0", 128'(v), 128'(blk[47:40]));
    wr(8'h83, 8'h10, 1'b0);
    peek(8'h89, v); chk("R5 key byte 5 in mode 1", 128'(v), 128'(key[47:40]));
    wr(8'h83, 8'h00, 1'b0);

    // R6: start through the mirror at the end of a burst
    wr(8'h94, 8'h80, 1'b1);
    chk("R6 launch pulse", 128'(eng_go), 128'h1);
    chk("R6 launch key", eng_key, key);
    chk("R6 launch block", eng_blk, blk);
    chk("R6 launch mode/dir", 128'({eng_mode, eng_decrypt}), 128'h0);
    @(negedge clk);
    chk("R6 launch lasts one cycle", 128'(eng_go), 128'h0);
    // R7: latency
    repeat (LAT - 2) @(negedge clk);
    peek(8'h82, v); chk("R7 done low at last busy cycle", 128'(v), 128'h00);
    @(negedge clk);
    peek(8'h82, v); chk("R7 done high after latency", 128'(v), 128'h01);
    res = model(key, blk, 1'b0);
    // R10: complete readout
    for (int i = 0; i < 16; i++) begin
      rd(8'(8'h84 + i), (i == 15), v);
      got[i*8 +: 8] = v;
    end
    chk("R7 result latched", got, res);
    peek(8'h82, v); chk("R10 full readout no error", 128'(v), 128'h01);

    // R8: control access while busy
    wr(8'h83, 8'h88, 1'b1);
    peek(8'h82, v); chk("R6 start clears done", 128'(v), 128'h00);
    rd(8'h83, 1'b0, v);
    wr(8'h83, 8'h20, 1'b1);
    repeat (LAT) @(negedge clk);
    peek(8'h82, v); chk("R8 error after busy control access", 128'(v), 128'h81);
    peek(8'h83, v); chk("R8 busy write ignored", 128'(v), 128'h08);
    res = model(key, res, 1'b1);

    // R9: partial readout after a fresh start
    wr(8'h94, 8'h80, 1'b1);
    peek(8'h82, v); chk("R6 start clears error", 128'(v), 128'h00);
    repeat (LAT) @(negedge clk);
    res = model(key, res, 1'b0);
    for (int i = 0; i < 5; i++) rd(8'(8'h84 + i), (i == 4), v);
    peek(8'h82, v); chk("R9 partial readout error", 128'(v), 128'h81);
    wr(8'h83, 8'h20, 1'b0);
    peek(8'h84, v); chk("R5 mode 2 reaches data block", 128'(v), 128'(res[7:0]));

    // R12: sleep abandons a running operation
    wr(8'h83, 8'h80, 1'b1);
    @(negedge clk);
    sleep_i = 1'b1;
    @(negedge clk);
    sleep_i = 1'b0;
    peek(8'h82, v); chk("R12 status cleared by sleep", 128'(v), 128'h00);
    peek(8'h83, v); chk("R12 control cleared by sleep", 128'(v), 128'h00);
    peek(8'h84, v); chk("R12 data cleared by sleep", 128'(v), 128'h00);
    repeat (LAT + 4) @(negedge clk);
    peek(8'h82, v); chk("R12 no done after sleep", 128'(v), 128'h00);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule